// File: doc/BRIEF.md
# I2C Register-Access Master

This block is a single-master I2C controller. It turns one host command into a complete register write or register read on a slave device. The host places a 1-bit direction, an 8-bit device address, an 8-bit register index and a write byte on the inputs, then pulses a strobe. The block runs the whole bus transaction. It then returns the read byte and an error flag with a one-cycle completion pulse.

Each bit period is split into four equal quarters of `QTR_CYC` clock cycles. SCL falls at the start of the first quarter and is released at the start of the third. SDA changes only at the start of the second or fourth quarter. Both lines are open-drain: the block only asserts an output enable that pulls a line low, and a high level comes from the external pull-up. After every transmitted byte the block polls for an acknowledge, clocking the bus repeatedly before it gives up. After reset it frees a possibly stuck bus with a series of stop sequences, and it accepts commands only after that.

Top module: `i2c_ra_master`

## Requirements
- R1: SCL is pulled low for exactly two quarters (2*QTR_CYC cycles) per symbol. An SDA enable change occurs exactly one quarter after SCL falls (SCL low) or three quarters after SCL falls (SCL high), never at any other point.
- R2: A start, including a repeated start, releases SDA in quarter 2, releases SCL in quarter 3, then pulls SDA low in quarter 4, so SDA falls while SCL is high.
- R3: A stop pulls SDA low in quarter 2, releases SCL in quarter 3, then releases SDA in quarter 4, so SDA rises while SCL is high. Every transaction ends with exactly one stop.
- R4: The outputs are only pull-low enables (`scl_oe_o`/`sda_oe_o` = 1 pulls the line to 0). In idle both enables are 0.
- R5: Transmitted bytes are sent as 8 bits, most-significant bit first.
- R6: After each transmitted byte the master releases SDA and clocks SCL, sampling SDA (through a two-flop synchronizer, at the end of quarter 3) on each pulse. It makes at most 255 sampled pulses in total, and the first pulse with SDA low is the acknowledge. If SDA stays high on all 255 pulses, the byte is unacknowledged.
- R7: `rd_i`=0 runs start, device address, register index, write byte, stop. An unacknowledged byte sets `err_o`, skips the remaining bytes and still issues the stop.
- R8: `rd_i`=1 runs start, device address, register index, repeated start, device address plus one, one received byte, stop. An unacknowledged byte sets `err_o`, skips to the stop, and leaves `rd_data_o` at 0.
- R9: The received byte is sampled over 8 released-SDA pulses and assembled from bit 7 down to bit 0. SDA stays released in the following ninth pulse, so no acknowledge is driven.
- R10: After reset the block issues exactly nine stop sequences with `busy_o`=1, and ignores any command until they are done.
- R11: `busy_o` rises on the cycle after an accepted strobe. `done_o` is a one-cycle pulse that comes with `err_o` and `rd_data_o` valid and `busy_o` already low. A strobe while `busy_o`=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Command strobe, taken when idle |
| rd_i | input | 1 | 1 = register read, 0 = register write |
| dev_addr_i | input | 8 | Slave address byte (bit 0 normally 0) |
| reg_idx_i | input | 8 | Slave register index |
| wr_data_i | input | 8 | Byte to write |
| rd_data_o | output | 8 | Byte read, valid with done_o |
| busy_o | output | 1 | Transaction or bus clear in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Some byte went unacknowledged, valid with done_o |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
A behavioural slave on the bus is fed a table of writes and reads. These include immediate acknowledges, acknowledges delayed by three pulses and by 254 pulses (the last allowed attempt), and no acknowledge at the address byte, the register byte or the read-address byte after the repeated start. Read-backs after a failed write show that the skipped data byte never reached the slave. The pulse counts in the acknowledge slot separate a delayed acknowledge from a give-up after 255 pulses. A monitor of quarter timing and start/stop counts separates repeated-start from plain sequences. Directed cases cover the nine-stop clear with a strobe sent during it, and a second strobe sent mid-transaction.

// File: rtl/i2c_ra_pkg.sv
package i2c_ra_pkg;
  typedef enum logic [1:0] {
    SYM_BIT   = 2'd0,
    SYM_START = 2'd1,
    SYM_STOP  = 2'd2
  } sym_kind_e;

  typedef enum logic [3:0] {
    ST_CLR, ST_IDLE, ST_START, ST_TX, ST_ACK, ST_RSTART, ST_RX, ST_RXACK, ST_STOP
  } seq_state_e;
endpackage

// File: rtl/i2c_ra_bit_engine.sv
module i2c_ra_bit_engine
  import i2c_ra_pkg::*;
#(
  parameter int QTR_CYC = 250
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sym_valid_i,
  input  sym_kind_e sym_kind_i,
  input  logic      sym_sda_i,
  output logic      sym_done_o,
  output logic      sample_o,
  input  logic      sda_i,
  output logic      scl_oe_o,
  output logic      sda_oe_o
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [1:0]    qtr_q;
  logic          act_q, scl_low_q, sda_low_q, done_q, smp_q, bit_q;
  logic [1:0]    sync_q;
  sym_kind_e     kind_q;
  logic          wrap;

  assign wrap = act_q && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], sda_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; qtr_q <= '0; act_q <= 1'b0;
      scl_low_q <= 1'b0; sda_low_q <= 1'b0;
      done_q <= 1'b0; smp_q <= 1'b1; bit_q <= 1'b1; kind_q <= SYM_BIT;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (sym_valid_i) begin
          act_q <= 1'b1; cnt_q <= '0; qtr_q <= 2'd0;
          kind_q <= sym_kind_i; bit_q <= sym_sda_i;
          scl_low_q <= 1'b1;                       // quarter 1
        end
      end else if (wrap) begin
        cnt_q <= '0;
        if (qtr_q == 2'd3) begin
          act_q <= 1'b0; done_q <= 1'b1;
        end else begin
          qtr_q <= qtr_q + 2'd1;
        end
        unique case (qtr_q)
          2'd0: begin                              // entering quarter 2
            unique case (kind_q)
              SYM_START: sda_low_q <= 1'b0;
              SYM_STOP:  sda_low_q <= 1'b1;
              default:   sda_low_q <= ~bit_q;
            endcase
          end
          2'd1: scl_low_q <= 1'b0;                 // entering quarter 3
          2'd2: begin                              // end of q3, entering q4
            smp_q <= sync_q[1];
            if (kind_q == SYM_START) sda_low_q <= 1'b1;
            else if (kind_q == SYM_STOP) sda_low_q <= 1'b0;
          end
          default: ;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sym_done_o = done_q;
  assign sample_o   = smp_q;
  assign scl_oe_o   = scl_low_q;
  assign sda_oe_o   = sda_low_q;

  // R1: SCL moves only on acceptance (falls) or leaving quarter 2 (rises)
  a_r1_scl_quarter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_low_q) |-> (!$past(act_q) || $past(qtr_q) == 2'd1));
  // R1: SDA moves only at entry to quarter 2 or quarter 4
  a_r1_sda_quarter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_low_q) |-> ($past(act_q) && ($past(qtr_q) == 2'd0 || $past(qtr_q) == 2'd2)));
  // R2/R3: SDA moves under high SCL only for start or stop
  a_r2_sda_high_scl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_low_q) && !scl_low_q) |-> ($past(kind_q) != SYM_BIT));
endmodule

// File: rtl/i2c_ra_seq.sv
module i2c_ra_seq
  import i2c_ra_pkg::*;
#(
  parameter int MAX_POLLS = 255,
  parameter int CLR_STOPS = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_i,
  input  logic       rd_i,
  input  logic [7:0] dev_addr_i,
  input  logic [7:0] reg_idx_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic       sym_valid_o,
  output sym_kind_e  sym_kind_o,
  output logic       sym_sda_o,
  input  logic       sym_done_i,
  input  logic       sample_i
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int KW = $clog2(CLR_STOPS + 1);

  seq_state_e    st_q;
  logic          wait_q, rd_q, err_q, done_q;
  logic [7:0]    addr_q, reg_q, wdat_q, sh_q, rx_q;
  logic [2:0]    bit_q;
  logic [1:0]    idx_q;
  logic [PW-1:0] poll_q;
  logic [KW-1:0] clr_q;

  function automatic logic [7:0] byte_sel(input logic [1:0] idx);
    unique case (idx)
      2'd0:    return addr_q;
      2'd1:    return reg_q;
      default: return rd_q ? (addr_q + 8'd1) : wdat_q;
    endcase
  endfunction

  always_comb begin
    sym_valid_o = (st_q != ST_IDLE) && !wait_q;
    sym_sda_o   = (st_q == ST_TX) ? sh_q[7] : 1'b1;
    if (st_q == ST_CLR || st_q == ST_STOP)         sym_kind_o = SYM_STOP;
    else if (st_q == ST_START || st_q == ST_RSTART) sym_kind_o = SYM_START;
    else                                           sym_kind_o = SYM_BIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_CLR; wait_q <= 1'b0; rd_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0;
      addr_q <= '0; reg_q <= '0; wdat_q <= '0; sh_q <= '0; rx_q <= '0;
      bit_q <= '0; idx_q <= '0; poll_q <= '0; clr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (sym_valid_o) wait_q <= 1'b1;
      if (st_q == ST_IDLE) begin
        if (cmd_i) begin
          rd_q <= rd_i; addr_q <= dev_addr_i; reg_q <= reg_idx_i; wdat_q <= wr_data_i;
          err_q <= 1'b0; rx_q <= '0; idx_q <= 2'd0; st_q <= ST_START;
        end
      end else if (sym_done_i) begin
        wait_q <= 1'b0;
        unique case (st_q)
          ST_CLR: begin
            if (clr_q == KW'(CLR_STOPS - 1)) st_q <= ST_IDLE;
            else clr_q <= clr_q + 1'b1;
          end
          ST_START, ST_RSTART: begin
            sh_q <= byte_sel(idx_q); bit_q <= '0; st_q <= ST_TX;
          end
          ST_TX: begin
            sh_q <= {sh_q[6:0], 1'b0}; bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin st_q <= ST_ACK; poll_q <= '0; end
          end
          ST_ACK: begin
            if (!sample_i) begin
              poll_q <= '0; bit_q <= '0;
              if (idx_q == 2'd0) begin
                idx_q <= 2'd1; sh_q <= reg_q; st_q <= ST_TX;
              end else if (idx_q == 2'd1) begin
                idx_q <= 2'd2;
                if (rd_q) st_q <= ST_RSTART;
                else begin sh_q <= wdat_q; st_q <= ST_TX; end
              end else begin
                st_q <= rd_q ? ST_RX : ST_STOP;
              end
            end else if (poll_q == PW'(MAX_POLLS - 1)) begin
              err_q <= 1'b1; st_q <= ST_STOP;
            end else begin
              poll_q <= poll_q + 1'b1;
            end
          end
          ST_RX: begin
            rx_q <= {rx_q[6:0], sample_i}; bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) st_q <= ST_RXACK;
          end
          ST_RXACK: st_q <= ST_STOP;
          ST_STOP: begin st_q <= ST_IDLE; done_q <= 1'b1; end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign rd_data_o = rx_q;

  // R11: busy follows an accepted strobe
  a_r11_busy_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && cmd_i) |=> busy_o);
  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10: the clear leads only to idle
  a_r10_clear_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CLR) |=> (st_q == ST_CLR || st_q == ST_IDLE));
  // R6: poll counter stays below the attempt limit
  a_r6_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q < PW'(MAX_POLLS));
  // R7: a raised error is always followed by the stop
  a_r7_stop_after_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> (st_q == ST_STOP));
endmodule

// File: rtl/i2c_ra_master.sv
module i2c_ra_master
  import i2c_ra_pkg::*;
#(
  parameter int QTR_CYC   = 250,
  parameter int MAX_POLLS = 255,
  parameter int CLR_STOPS = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_i,
  input  logic       rd_i,
  input  logic [7:0] dev_addr_i,
  input  logic [7:0] reg_idx_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  input  logic       sda_i
);
  logic      sym_valid, sym_sda, sym_done, sample;
  sym_kind_e sym_kind;

  i2c_ra_seq #(.MAX_POLLS(MAX_POLLS), .CLR_STOPS(CLR_STOPS)) i_seq (
    .clk_i, .rst_ni, .cmd_i, .rd_i, .dev_addr_i, .reg_idx_i, .wr_data_i,
    .rd_data_o, .busy_o, .done_o, .err_o,
    .sym_valid_o(sym_valid), .sym_kind_o(sym_kind), .sym_sda_o(sym_sda),
    .sym_done_i(sym_done), .sample_i(sample)
  );

  i2c_ra_bit_engine #(.QTR_CYC(QTR_CYC)) i_eng (
    .clk_i, .rst_ni,
    .sym_valid_i(sym_valid), .sym_kind_i(sym_kind), .sym_sda_i(sym_sda),
    .sym_done_o(sym_done), .sample_o(sample),
    .sda_i, .scl_oe_o, .sda_oe_o
  );
endmodule

// File: tb/test_i2c_ra_master.sv
`timescale 1ns/1ps
module test_i2c_ra_master;
  localparam int Q = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, regi = '0, wdat = '0;
  logic [7:0] rd_data;
  logic busy, done, err, scl_oe, sda_oe;
  logic s_pull = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || s_pull);

  always #2.5 clk = ~clk;

  i2c_ra_master #(.QTR_CYC(Q)) i_i2c_ra_master (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .rd_i(rd),
    .dev_addr_i(addr), .reg_idx_i(regi), .wr_data_i(wdat),
    .rd_data_o(rd_data), .busy_o(busy), .done_o(done), .err_o(err),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  int sst = 0, bitn = 0, gbyte = 0, dly_left = 0, pulses = 0, last_pulses = 0;
  int starts = 0, stops = 0, cfg_dly = 0, cfg_nack = 3;
  logic first = 1'b0, mack_val = 1'b0;
  logic [7:0] sh = '0, ptr = '0, tx = '0;
  logic [7:0] mem [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
  logic [7:0] log_b [3] = '{8'h00, 8'h00, 8'h00};

  always @(negedge sda_line) if (rst_n === 1'b1 && scl_line === 1'b1) begin
    starts++; sst = 1; bitn = 0; s_pull = 1'b0; first = 1'b1;
  end
  always @(posedge sda_line) if (rst_n === 1'b1 && scl_line === 1'b1) begin
    stops++;
    if (sst == 2) last_pulses = pulses;
    sst = 0; gbyte = 0; s_pull = 1'b0;
  end
  always @(posedge scl_line) if (rst_n === 1'b1) begin
    if (sst == 1) begin sh = {sh[6:0], sda_line}; bitn++; end
    else if (sst == 3) bitn++;
    else if (sst == 4) mack_val = sda_line;
  end
  always @(negedge scl_line) if (rst_n === 1'b1) begin
    case (sst)
      1: if (bitn == 8) begin
        if (gbyte < 3) log_b[gbyte] = sh;
        sst = 2; pulses = 0; dly_left = cfg_dly;
        if (gbyte != cfg_nack && dly_left == 0) s_pull = 1'b1;
      end
      2: begin
        pulses++;
        if (s_pull) begin
          s_pull = 1'b0; last_pulses = pulses;
          if (gbyte == 1) ptr = sh;
          if (gbyte == 2 && !first) mem[ptr[1:0]] = sh;
          gbyte++;
          if (first && sh[0]) begin
            sst = 3; bitn = 0; tx = mem[ptr[1:0]]; s_pull = !tx[7];
          end else begin
            sst = 1; bitn = 0;
          end
          first = 1'b0;
        end else if (gbyte != cfg_nack) begin
          dly_left--;
          if (dly_left == 0) s_pull = 1'b1;
        end
      end
      3: if (bitn == 8) begin
        s_pull = 1'b0; sst = 4;
      end else begin
        tx = {tx[6:0], 1'b0}; s_pull = !tx[7];
      end
      4: sst = 0;
      default: ;
    endcase
  end

  // ---------------- R1 timing monitor ----------------
  int cyc = 0, t_fall = 0, r1_bad = 0, r1_evt = 0;
  logic prev_scl = 1'b0, prev_sda = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (scl_oe && !prev_scl) t_fall = cyc;
      if (!scl_oe && prev_scl) begin
        r1_evt++;
        if (cyc - t_fall != 2*Q) r1_bad++;
      end
      if (sda_oe != prev_sda) begin
        r1_evt++;
        if (!(cyc - t_fall == Q || cyc - t_fall == 3*Q)) r1_bad++;
      end
    end
    prev_scl = scl_oe; prev_sda = sda_oe;
  end

  // ---------------- vectors ----------------
  typedef struct packed {
    logic       rw;
    logic [7:0] a, r, d, dly;
    logic [1:0] nack;
    logic       e;
    logic [7:0] exp_rd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'hA0, 8'h01, 8'h5A, 8'd0,   2'd3, 1'b0, 8'h00},
    '{1'b1, 8'hA0, 8'h01, 8'h00, 8'd0,   2'd3, 1'b0, 8'h5A},
    '{1'b0, 8'h3C, 8'h02, 8'h81, 8'd3,   2'd3, 1'b0, 8'h00},
    '{1'b1, 8'h3C, 8'h02, 8'h00, 8'd3,   2'd3, 1'b0, 8'h81},
    '{1'b0, 8'h50, 8'h03, 8'hFF, 8'd0,   2'd1, 1'b1, 8'h00},
    '{1'b1, 8'h50, 8'h03, 8'h00, 8'd0,   2'd3, 1'b0, 8'h44},
    '{1'b1, 8'h50, 8'h01, 8'h00, 8'd0,   2'd0, 1'b1, 8'h00},
    '{1'b0, 8'h6E, 8'h00, 8'h00, 8'd254, 2'd3, 1'b0, 8'h00},
    '{1'b1, 8'h6E, 8'h00, 8'h00, 8'd0,   2'd3, 1'b0, 8'h00},
    '{1'b1, 8'hA0, 8'h01, 8'h00, 8'd0,   2'd2, 1'b1, 8'h00}
  };

  task automatic strobe(input vec_t v);
    @(negedge clk);
    rd = v.rw; addr = v.a; regi = v.r; wdat = v.d; cmd = 1'b1;
    @(negedge clk);
    cmd = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0, p0;
    repeat (3) @(negedge clk);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R4 lines released in reset", {scl_oe, sda_oe}, 0);
    chk(busy == 1'b0 || busy == 1'b1, "R10 busy known", busy, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R10 busy during bus clear", busy, 1);
    s0 = starts;
    strobe('{1'b0, 8'hA0, 8'h00, 8'hEE, 8'd0, 2'd3, 1'b0, 8'h00});
    while (busy) @(negedge clk);
    chk(stops == 9, "R10 nine stops after reset", stops, 9);
    chk(starts == s0, "R10 strobe during clear ignored", starts - s0, 0);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R4 lines released idle", {scl_oe, sda_oe}, 0);
    repeat (20) @(negedge clk);
    chk(!busy && starts == s0, "R10 no late start from ignored strobe", starts - s0, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      int st0, sp0, exp_st;
      cfg_dly = int'(v.dly); cfg_nack = int'(v.nack);
      log_b = '{8'h00, 8'h00, 8'h00}; mack_val = 1'b0;
      st0 = starts; sp0 = stops;
      @(negedge clk);
      rd = v.rw; addr = v.a; regi = v.r; wdat = v.d; cmd = 1'b1;
      @(negedge clk);
      cmd = 1'b0;
      chk(busy == 1'b1, "R11 busy next cycle", busy, 1);
      wait_done();
      chk(busy == 1'b0, "R11 busy low with done", busy, 0);
      chk(err == v.e, "R7/R8 err flag", err, v.e);
      if (v.rw) chk(rd_data == v.exp_rd, "R8/R9 read data", rd_data, v.exp_rd);
      @(negedge clk);
      chk(done == 1'b0, "R11 done one cycle", done, 0);
      chk(stops - sp0 == 1, "R3 one stop per transaction", stops - sp0, 1);
      exp_st = (v.rw && v.nack >= 2) ? 2 : 1;
      chk(starts - st0 == exp_st, "R2 start count", starts - st0, exp_st);
      chk(log_b[0] == v.a, "R5 address byte msb first", log_b[0], v.a);
      if (v.nack != 0) chk(log_b[1] == v.r, "R5 register byte", log_b[1], v.r);
      if (!v.rw && v.nack == 3) chk(log_b[2] == v.d, "R7 write byte", log_b[2], v.d);
      if (v.rw && v.nack >= 2) chk(log_b[2] == v.a + 8'd1, "R8 address plus one", log_b[2], v.a + 8'd1);
      if (v.rw && v.nack == 3) chk(mack_val == 1'b1, "R9 ack slot released", mack_val, 1);
      chk(last_pulses == ((v.nack != 3) ? 255 : int'(v.dly) + 1), "R6 ack pulse count",
          last_pulses, (v.nack != 3) ? 255 : int'(v.dly) + 1);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R4 lines released after", {scl_oe, sda_oe}, 0);
      repeat (5) @(negedge clk);
    end

    // R11: strobe while busy is ignored
    cfg_dly = 0; cfg_nack = 3;
    s0 = starts; p0 = stops;
    strobe('{1'b0, 8'hA0, 8'h02, 8'h77, 8'd0, 2'd3, 1'b0, 8'h00});
    repeat (100) @(negedge clk);
    strobe('{1'b1, 8'h3C, 8'h01, 8'h00, 8'd0, 2'd3, 1'b0, 8'h00});
    wait_done();
    repeat (600) @(negedge clk);
    chk(starts - s0 == 1 && stops - p0 == 1, "R11 busy strobe ignored", starts - s0, 1);
    chk(!busy, "R11 idle after ignored strobe", busy, 0);
    chk(mem[2] == 8'h77, "R7 write landed", mem[2], 8'h77);

    chk(r1_evt > 100 && r1_bad == 0, "R1 quarter timing violations", r1_bad, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule